// File: doc/BRIEF.md
# Ripple-Cascaded Bit-Slice Magnitude Comparator

This block compares two operands of parameterized width with purely combinational logic. It is built from identical one-bit stages. Each stage looks at one pair of operand bits and at a pair of flags from the stage below it, one meaning "the lower bits say A is larger" and one meaning "the lower bits say A is smaller". It then passes its own pair of flags to the stage above. The decision travels from the least significant bit up to the most significant one. The top stage gives the unsigned greater and less results. Equality is taken from the case where neither of those is raised.

Signed results come out at the same time. A second copy of the top stage receives the shared lower-bit flags, but the operand bits are exchanged at its inputs. A set sign bit therefore counts as the smaller value, which gives a two's-complement compare. Two flag inputs at the bottom of the chain let several units be stacked into a wider comparator. A standalone unit ties both of them low.

Top module: `ripple_mag_cmp`

## Requirements
- R1: With both cascade inputs low, `ugt_o` is 1 exactly when `a_i` is larger than `b_i` as unsigned numbers.
- R2: With both cascade inputs low, `ult_o` is 1 exactly when `a_i` is smaller than `b_i` as unsigned numbers.
- R3: `eq_o` is 1 exactly when `a_i` equals `b_i` and both cascade inputs are low.
- R4: With both cascade inputs low, `sgt_o` and `slt_o` give greater and less for the operands read as two's-complement numbers (bit WIDTH-1 is the sign).
- R5: Whenever the cascade inputs are not both high, exactly one of `ugt_o`, `eq_o` and `ult_o` is 1.
- R6: When `a_i` equals `b_i`, `ugt_o` and `sgt_o` follow `gt_cin`, and `ult_o` and `slt_o` follow `lt_cin`.
- R7: When `a_i` differs from `b_i`, the cascade inputs have no effect on any output.
- R8: With WIDTH = 1, the single bit is the sign for the signed outputs, so a = 1 is signed-less than b = 0 and unsigned-greater than it.
- R9: With both cascade inputs high and equal operands, `ugt_o`, `ult_o`, `sgt_o` and `slt_o` are all 1 and `eq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| gt_cin | input | 1 | Flag from a lower unit saying A is greater; tie low when used alone |
| lt_cin | input | 1 | Flag from a lower unit saying A is less; tie low when used alone |
| ugt_o | output | 1 | A greater than B, unsigned |
| eq_o | output | 1 | A equal to B, with no pending cascade decision |
| ult_o | output | 1 | A less than B, unsigned |
| sgt_o | output | 1 | A greater than B, two's complement |
| slt_o | output | 1 | A less than B, two's complement |

## Verification
The bench applies every operand pair at four bits together with all four cascade settings. It then repeats the sweep on a one-bit instance. Pairs that differ only in the sign bit show whether the sign stage swaps the operands correctly: without the swap, the signed outputs would copy the unsigned ones. Pairs whose only difference is a low bit show whether the lower decision reaches the top stage: a broken ripple gives equal or wrong ordering. Equal pairs with a cascade flag set show whether equality is gated by those flags: a design that ignores them raises `eq_o` while also forwarding a greater or less flag.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Pair of ordering flags passed from one slice to the next.
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_flags_t;

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
(
    input  logic       x_i,
    input  logic       y_i,
    input  cmp_flags_t fl_in,
    output cmp_flags_t fl_out
);

    logic       bit_match;
    cmp_flags_t fl_d;

    always_comb begin
        // XNOR equality of the local bit pair
        bit_match = ~(x_i ^ y_i);
        fl_d.gt   = (x_i & ~y_i) | (bit_match & fl_in.gt);
        fl_d.lt   = (~x_i & y_i) | (bit_match & fl_in.lt);
    end

    assign fl_out = fl_d;

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
    import cmp_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic [DEPTH-1:0] x_i,
    input  logic [DEPTH-1:0] y_i,
    input  cmp_flags_t       fl_in,
    output cmp_flags_t       fl_out
);

    cmp_flags_t link [DEPTH+1];

    assign link[0] = fl_in;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        cmp_slice u_slice (
            .x_i    (x_i[g]),
            .y_i    (y_i[g]),
            .fl_in  (link[g]),
            .fl_out (link[g+1])
        );
    end

    assign fl_out = link[DEPTH];

endmodule

// File: rtl/ripple_mag_cmp.sv
module ripple_mag_cmp
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             gt_cin,
    input  logic             lt_cin,
    output logic             ugt_o,
    output logic             eq_o,
    output logic             ult_o,
    output logic             sgt_o,
    output logic             slt_o
);

    localparam int MSB = WIDTH - 1;

    cmp_flags_t ext_d;
    cmp_flags_t low_d;
    cmp_flags_t uns_d;
    cmp_flags_t sgn_d;

    assign ext_d.gt = gt_cin;
    assign ext_d.lt = lt_cin;

    if (WIDTH > 1) begin : g_lower
        cmp_ripple_chain #(.DEPTH(MSB)) u_chain (
            .x_i    (a_i[MSB-1:0]),
            .y_i    (b_i[MSB-1:0]),
            .fl_in  (ext_d),
            .fl_out (low_d)
        );
    end else begin : g_no_lower
        assign low_d = ext_d;
    end

    // Top slice, unsigned reading of the sign bit
    cmp_slice u_top_uns (
        .x_i    (a_i[MSB]),
        .y_i    (b_i[MSB]),
        .fl_in  (low_d),
        .fl_out (uns_d)
    );

    // Top slice with operand bits exchanged: a set sign bit ranks lower
    cmp_slice u_top_sgn (
        .x_i    (b_i[MSB]),
        .y_i    (a_i[MSB]),
        .fl_in  (low_d),
        .fl_out (sgn_d)
    );

    always_comb begin
        ugt_o = uns_d.gt;
        ult_o = uns_d.lt;
        eq_o  = ~uns_d.gt & ~uns_d.lt;
        sgt_o = sgn_d.gt;
        slt_o = sgn_d.lt;
    end

endmodule

// File: rtl/ripple_mag_cmp_chk.sv
module ripple_mag_cmp_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             gt_cin,
    input logic             lt_cin,
    input logic             ugt_o,
    input logic             eq_o,
    input logic             ult_o,
    input logic             sgt_o,
    input logic             slt_o
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        p_eq_only_when_equal_r3: assert (!eq_o || (a_i == b_i && !gt_cin && !lt_cin))
            else $error("eq_o high for unequal operands or pending cascade");
        p_one_result_r5: assert ((gt_cin && lt_cin) || $onehot({ugt_o, eq_o, ult_o}))
            else $error("unsigned results not exclusive");
        p_follow_cascade_r6: assert (a_i != b_i ||
                                     (ugt_o == gt_cin && ult_o == lt_cin &&
                                      sgt_o == gt_cin && slt_o == lt_cin))
            else $error("equal operands did not forward cascade flags");
        p_same_sign_r4: assert (a_i[MSB] != b_i[MSB] || (sgt_o == ugt_o && slt_o == ult_o))
            else $error("signed and unsigned disagree with equal sign bits");
        p_sign_decides_r4: assert (a_i[MSB] == b_i[MSB] || (slt_o == a_i[MSB] && sgt_o == b_i[MSB]))
            else $error("sign bits did not decide signed result");
    end

endmodule

bind ripple_mag_cmp ripple_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .gt_cin (gt_cin),
    .lt_cin (lt_cin),
    .ugt_o  (ugt_o),
    .eq_o   (eq_o),
    .ult_o  (ult_o),
    .sgt_o  (sgt_o),
    .slt_o  (slt_o)
);

// File: tb/test_ripple_mag_cmp.sv
module test_ripple_mag_cmp;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] a, b;
    logic gi, li;
    logic ugt, eq, ult, sgt, slt;

    logic a1, b1, gi1, li1;
    logic ugt1, eq1, ult1, sgt1, slt1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ripple_mag_cmp #(.WIDTH(W)) i_ripple_mag_cmp (
        .a_i(a), .b_i(b), .gt_cin(gi), .lt_cin(li),
        .ugt_o(ugt), .eq_o(eq), .ult_o(ult), .sgt_o(sgt), .slt_o(slt)
    );

    ripple_mag_cmp #(.WIDTH(1)) i_ripple_mag_cmp_w1 (
        .a_i(a1), .b_i(b1), .gt_cin(gi1), .lt_cin(li1),
        .ugt_o(ugt1), .eq_o(eq1), .ult_o(ult1), .sgt_o(sgt1), .slt_o(slt1)
    );

    task automatic check(input logic act, input logic exp, input string req,
                         input string what, input int va, input int vb,
                         input logic g, input logic l);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s a=%0d b=%0d gin=%0b lin=%0b actual=%0b expected=%0b",
                     req, what, va, vb, g, l, act, exp);
        end
    endtask

    // Expected result with cascade flags applied on a tie
    function automatic logic want_gt(input int x, input int y, input logic g);
        return (x > y) || (x == y && g);
    endfunction
    function automatic logic want_lt(input int x, input int y, input logic l);
        return (x < y) || (x == y && l);
    endfunction

    function automatic string tag(input int x, input int y, input logic g,
                                  input logic l, input string base);
        if (x == y && g && l) return "R9";
        if (x == y && (g || l)) return "R6";
        if (x != y && (g || l)) return "R7";
        return base;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        // Initial state: zero operands, idle cascade
        a = '0; b = '0; gi = 1'b0; li = 1'b0;
        a1 = 1'b0; b1 = 1'b0; gi1 = 1'b0; li1 = 1'b0;
        @(negedge clk);
        check(eq, 1'b1, "R3", "eq at start", 0, 0, 1'b0, 1'b0);
        check(ugt | ult, 1'b0, "R5", "order at start", 0, 0, 1'b0, 1'b0);

        for (int c = 0; c < 4; c++) begin
            for (int ia = 0; ia < (1 << W); ia++) begin
                for (int ib = 0; ib < (1 << W); ib++) begin
                    logic g, l;
                    int sa, sb;
                    g = c[0]; l = c[1];
                    a = W'(ia); b = W'(ib); gi = g; li = l;
                    sa = (ia >= (1 << (W-1))) ? ia - (1 << W) : ia;
                    sb = (ib >= (1 << (W-1))) ? ib - (1 << W) : ib;
                    #(CLK_PERIOD/2);
                    check(ugt, want_gt(ia, ib, g), tag(ia, ib, g, l, "R1"), "ugt", ia, ib, g, l);
                    check(ult, want_lt(ia, ib, l), tag(ia, ib, g, l, "R2"), "ult", ia, ib, g, l);
                    check(eq, (ia == ib) && !g && !l, tag(ia, ib, g, l, "R3"), "eq", ia, ib, g, l);
                    check(sgt, want_gt(sa, sb, g), tag(ia, ib, g, l, "R4"), "sgt", sa, sb, g, l);
                    check(slt, want_lt(sa, sb, l), tag(ia, ib, g, l, "R4"), "slt", sa, sb, g, l);
                    if (!(g && l))
                        check(logic'((ugt + eq + ult) == 1), 1'b1, "R5", "exclusive", ia, ib, g, l);
                end
            end
        end

        // R8: one-bit instance, the only bit is the sign
        for (int c = 0; c < 4; c++) begin
            for (int ia = 0; ia < 2; ia++) begin
                for (int ib = 0; ib < 2; ib++) begin
                    logic g, l;
                    int sa, sb;
                    g = c[0]; l = c[1];
                    a1 = ia[0]; b1 = ib[0]; gi1 = g; li1 = l;
                    sa = -ia; sb = -ib;
                    #(CLK_PERIOD/2);
                    check(ugt1, want_gt(ia, ib, g), "R8", "w1 ugt", ia, ib, g, l);
                    check(ult1, want_lt(ia, ib, l), "R8", "w1 ult", ia, ib, g, l);
                    check(eq1, (ia == ib) && !g && !l, "R8", "w1 eq", ia, ib, g, l);
                    check(sgt1, want_gt(sa, sb, g), "R8", "w1 sgt", sa, sb, g, l);
                    check(slt1, want_lt(sa, sb, l), "R8", "w1 slt", sa, sb, g, l);
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule